// File: doc/BRIEF.md
# Paged MII Management Register File

This block holds the management register space of an Ethernet PHY and sits behind the deserialiser of a serial management interface. It has one clocked access port: a 5-bit address, a 16-bit write word and a registered 16-bit read word. Software selects which bank it sees through a page selector that always lives at address 31.

Four page codes are recognised. Code 0 shows the main bank. Codes 1 and 2 replace only addresses 16–30 with one of two extended banks. Code 0x10 replaces the whole window, addresses 0–30, with a general-purpose bank. Any other code acts as code 0.

Every register has its own mask of writable bits. The rest of its bits are reserved: they read as zero and ignore writes. A soft reset is started by writing bit 15 of control register 0. It returns every bit to its default except the bits marked sticky. Bit 11 of control register 0 is the power-down control and drives a port.

Top module: `pmr_top`

## Requirements
- R1: A read (acc_en=1, acc_wr=0) returns its data on rd_data, with rd_valid=1, in the cycle after the request. In any other cycle rd_valid is 0 and rd_data keeps its last value.
- R2: Address 31 is the page selector on every page. Its bits 4:0 are writable, bits 15:5 read 0, and it resets to 0.
- R3: With page code 0x0001, addresses 16–30 reach extended bank 1. Addresses 0–15 still reach the main registers.
- R4: With page code 0x0002, addresses 16–30 reach extended bank 2.
- R5: With page code 0x0010, addresses 0–30 reach the general-purpose bank. A write to address 0 on this page does not start a soft reset.
- R6: Page code 0 and every code other than 0x0001, 0x0002 and 0x0010 decode as the main page.
- R7: Writable bits per register:
  - main address 0: bits 14:0
  - main addresses 1–15: bits 7:0
  - main addresses 16–30: bits 11:0
  - extended bank 1: bits 13:0
  - extended bank 2: bits 15:4
  - general-purpose bank: all 16 bits
  
  All other bits read 0.
- R8: After a hard reset (rst_n low), main register 0 reads 0x1140 and every other register reads 0.
- R9: A write to address 0, while that address reaches the main bank, with bit 15 set starts a soft reset. It drops the rest of the written word, and every non-sticky bit returns to its R8 default. The page selector returns to 0, and bit 15 of register 0 always reads 0.
- R10: Sticky bits, which keep their value through a soft reset:
  - main 16–30: bits 11:8
  - extended bank 1: bits 13:12
  - extended bank 2: bits 11:8
  - general-purpose bank: bits 15:8
  
  No other register has sticky bits.
- R11: pwr_down always equals bit 11 of main register 0.
- R12: A write to the page selector takes effect on the very next access, including one issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register address in the current window |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Registered read data |
| pwr_down | output | 1 | Power-down control, bit 11 of main register 0 |

## Verification
Two things can meet in back-to-back cycles: a change of page, and the decode of the access that follows it. The same holds for a soft reset, which clears the page selector, and the next access, which must already see the main page. The bench issues page writes and soft-reset writes directly before reads and writes to the remapped addresses, both in directed sequences and in a random mix. It judges every read against a bench model that applies the page change before decoding the next address.

// File: rtl/pmr_pkg.sv
// Shared types and per-register attributes of the paged register file.
// Assumes 16-bit registers and a 5-bit address; attribute functions are
// evaluated at elaboration time only.
package pmr_pkg;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int EXT_LO = 16;
    localparam int TOP_IDX = 30;
    localparam int PAGE_ADDR = 31;
    localparam logic [DW-1:0] PG_MAIN = 16'h0000;
    localparam logic [DW-1:0] PG_E1 = 16'h0001;
    localparam logic [DW-1:0] PG_E2 = 16'h0002;
    localparam logic [DW-1:0] PG_GP = 16'h0010;
    localparam logic [DW-1:0] PAGE_WMASK = 16'h001F;
    localparam logic [DW-1:0] CTRL0_DFLT = 16'h1140;
    localparam logic [DW-1:0] CTRL0_WMASK = 16'h7FFF;
    localparam int SRST_BIT = 15;
    localparam int PD_BIT = 11;

    typedef enum logic [1:0] {BK_MAIN, BK_EXT1, BK_EXT2, BK_GP} bank_e;
    typedef enum logic [2:0] {T_CTRL0, T_MAIN, T_EXT1, T_EXT2, T_GP, T_PAGE} tgt_e;

    // Writable-bit mask of register i in bank b.
    function automatic logic [DW-1:0] reg_wmask(bank_e b, int i);
        case (b)
            BK_MAIN: return (i < EXT_LO) ? 16'h00FF : 16'h0FFF;
            BK_EXT1: return 16'h3FFF;
            BK_EXT2: return 16'hFFF0;
            default: return 16'hFFFF;
        endcase
    endfunction

    // Bits of register i in bank b that survive a soft reset.
    function automatic logic [DW-1:0] reg_smask(bank_e b, int i);
        case (b)
            BK_MAIN: return (i < EXT_LO) ? 16'h0000 : 16'h0F00;
            BK_EXT1: return 16'h3000;
            BK_EXT2: return 16'h0F00;
            default: return 16'hFF00;
        endcase
    endfunction
endpackage

// File: rtl/pmr_decode.sv
// Address decoder: maps address and page code to a target store.
// Assumes the page code arrives already masked to its writable bits.
module pmr_decode
    import pmr_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] page,
    output tgt_e          tgt
);
    // Pick the store reached by this address under the current page.
    always_comb begin
        if (addr == AW'(PAGE_ADDR))
            tgt = T_PAGE;
        else if (page == PG_GP)
            tgt = T_GP;
        else if (addr >= AW'(EXT_LO))
            tgt = (page == PG_E1) ? T_EXT1 : (page == PG_E2) ? T_EXT2 : T_MAIN;
        else if (addr == '0)
            tgt = T_CTRL0;
        else
            tgt = T_MAIN;
    end
endmodule

// File: rtl/pmr_bank.sv
// One bank of masked registers at indices FIRST..LAST.
// Reserved bits hold 0; sticky bits keep their value on soft_rst.
// Assumes idx is shared by the read and the write path.
module pmr_bank
    import pmr_pkg::*;
#(
    parameter bank_e BANK = BK_MAIN,
    parameter int FIRST = 0,
    parameter int LAST = 30
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] q [FIRST:LAST];

    for (genvar g = FIRST; g <= LAST; g++) begin : g_reg
        localparam logic [DW-1:0] WM = reg_wmask(BANK, g);
        localparam logic [DW-1:0] SM = reg_smask(BANK, g);
        // Hold one register: clear, keep sticky bits, or merge a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (soft_rst)
                q[g] <= q[g] & SM;
            else if (wr_en && idx == AW'(g))
                q[g] <= (q[g] & ~WM) | (wdata & WM);
        end
    end

    // Select the addressed register for reading.
    always_comb begin
        rdata = '0;
        for (int k = FIRST; k <= LAST; k++)
            if (idx == AW'(k)) rdata = q[k];
    end
endmodule

// File: rtl/pmr_ctrl0.sv
// Main control register 0: bit 15 is a self-clearing soft reset,
// never stored; other writable bits are plain control, non-sticky.
module pmr_ctrl0
    import pmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          soft_rst,
    output logic [DW-1:0] q
);
    // A write with the reset bit set requests a soft reset.
    assign soft_rst = wr_en && wdata[SRST_BIT];

    // Hold the control word; soft reset reloads the default.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            q <= CTRL0_DFLT;
        else if (wr_en)
            q <= wdata & CTRL0_WMASK;
    end
endmodule

// File: rtl/pmr_top.sv
// Paged management register file with one registered access port.
// Assumes at most one access per cycle; reads return a cycle later.
module pmr_top
    import pmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          pwr_down
);
    tgt_e          tgt;
    logic [DW-1:0] page_q;
    logic [DW-1:0] ctrl0_q;
    logic [DW-1:0] main_rd, e1_rd, e2_rd, gp_rd;
    logic          wr, soft_rst;
    logic          rd_req;

    assign wr     = acc_en && acc_wr;
    assign rd_req = acc_en && !acc_wr;

    pmr_decode u_dec (.addr(acc_addr), .page(page_q), .tgt(tgt));

    pmr_ctrl0 u_ctrl0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr && tgt == T_CTRL0),
        .wdata(acc_wdata), .soft_rst(soft_rst), .q(ctrl0_q)
    );

    pmr_bank #(.BANK(BK_MAIN), .FIRST(1), .LAST(TOP_IDX)) u_main (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr && tgt == T_MAIN),
        .idx(acc_addr), .wdata(acc_wdata), .rdata(main_rd)
    );
    pmr_bank #(.BANK(BK_EXT1), .FIRST(EXT_LO), .LAST(TOP_IDX)) u_ext1 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr && tgt == T_EXT1),
        .idx(acc_addr), .wdata(acc_wdata), .rdata(e1_rd)
    );
    pmr_bank #(.BANK(BK_EXT2), .FIRST(EXT_LO), .LAST(TOP_IDX)) u_ext2 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr && tgt == T_EXT2),
        .idx(acc_addr), .wdata(acc_wdata), .rdata(e2_rd)
    );
    pmr_bank #(.BANK(BK_GP), .FIRST(0), .LAST(TOP_IDX)) u_gp (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr && tgt == T_GP),
        .idx(acc_addr), .wdata(acc_wdata), .rdata(gp_rd)
    );

    // Page selector: masked write, cleared by hard and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            page_q <= PG_MAIN;
        else if (wr && tgt == T_PAGE)
            page_q <= acc_wdata & PAGE_WMASK;
    end

    // Register the read word of the addressed target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                case (tgt)
                    T_CTRL0: rd_data <= ctrl0_q;
                    T_MAIN:  rd_data <= main_rd;
                    T_EXT1:  rd_data <= e1_rd;
                    T_EXT2:  rd_data <= e2_rd;
                    T_GP:    rd_data <= gp_rd;
                    default: rd_data <= page_q;
                endcase
            end
        end
    end

    assign pwr_down = ctrl0_q[PD_BIT];
endmodule

// File: rtl/pmr_chk.sv
// Checker for pmr_top: port timing, page selector and soft-reset rules.
// Attached by bind; observes the page selector as internal state.
module pmr_chk
    import pmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          acc_en,
    input logic          acc_wr,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_wdata,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic          pwr_down,
    input logic [DW-1:0] page_q
);
    a_r1_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> rd_valid);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> (!rd_valid && $stable(rd_data)));
    a_r2_page_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == AW'(PAGE_ADDR)) |=> page_q == ($past(acc_wdata) & PAGE_WMASK));
    a_r2_page_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_addr == AW'(PAGE_ADDR)) |=> rd_data == $past(page_q));
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == '0 && acc_wdata[SRST_BIT] && page_q != PG_GP)
        |=> (page_q == PG_MAIN && !pwr_down));
    a_r5_gp_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == '0 && page_q == PG_GP) |=> ($stable(page_q) && $stable(pwr_down)));
    a_r11_pd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_wr && acc_addr == '0) |=> $stable(pwr_down));
endmodule

bind pmr_top pmr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pwr_down(pwr_down), .page_q(page_q)
);

// File: tb/test_pmr_top.sv
`timescale 1ns/1ps
module test_pmr_top;
    localparam int AW = 5;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0, acc_en = 0, acc_wr = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic rd_valid, pwr_down;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    pmr_top i_pmr_top (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .pwr_down(pwr_down)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [DW-1:0] mdl [4][32];
    logic [DW-1:0] mpage;
    logic [DW-1:0] last_rd;

    // Writable mask from R7 (bank 0 main, 1 ext1, 2 ext2, 3 general purpose).
    function automatic logic [DW-1:0] wm(int b, int i);
        if (b == 0) return (i == 0) ? 16'h7FFF : (i < 16) ? 16'h00FF : 16'h0FFF;
        if (b == 1) return 16'h3FFF;
        if (b == 2) return 16'hFFF0;
        return 16'hFFFF;
    endfunction
    // Sticky mask from R10.
    function automatic logic [DW-1:0] sm(int b, int i);
        if (b == 0) return (i < 16) ? 16'h0000 : 16'h0F00;
        if (b == 1) return 16'h3000;
        if (b == 2) return 16'h0F00;
        return 16'hFF00;
    endfunction
    // Defaults from R8.
    function automatic logic [DW-1:0] df(int b, int i);
        return (b == 0 && i == 0) ? 16'h1140 : 16'h0000;
    endfunction
    // Target per R2-R6: 4 means the page selector.
    function automatic int bank_of(int a);
        if (a == 31) return 4;
        if (mpage == 16'h0010) return 3;
        if (a >= 16 && mpage == 16'h0001) return 1;
        if (a >= 16 && mpage == 16'h0002) return 2;
        return 0;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mdl_reset(bit hard);
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 32; i++)
                mdl[b][i] = hard ? df(b, i) : ((mdl[b][i] & sm(b, i)) | (df(b, i) & ~sm(b, i)));
        mpage = '0;
    endtask

    // Entered at a negedge; one access cycle, returns at the next negedge.
    task automatic do_write(int a, logic [DW-1:0] d);
        int b;
        b = bank_of(a);
        acc_en = 1; acc_wr = 1; acc_addr = AW'(a); acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
        if (b == 4) mpage = d & 16'h001F;
        else if (b == 0 && a == 0 && d[15]) mdl_reset(0);
        else mdl[b][a] = (mdl[b][a] & ~wm(b, a)) | (d & wm(b, a));
        check("R1 hold valid", DW'(rd_valid), '0);
        check("R1 hold data", rd_data, last_rd);
    endtask

    task automatic do_read(int a, string req);
        int b;
        logic [DW-1:0] exp;
        b = bank_of(a);
        exp = (b == 4) ? mpage : mdl[b][a];
        acc_en = 1; acc_wr = 0; acc_addr = AW'(a);
        @(negedge clk);
        acc_en = 0;
        check(req, rd_data, exp);
        check("R1 valid", DW'(rd_valid), 16'h0001);
        check("R11 pwr_down", DW'(pwr_down), DW'(mdl[0][0][11]));
        last_rd = rd_data;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int a, sel;
        logic [DW-1:0] d;
        seed = 32'd2024;
        void'($urandom(seed));
        mdl_reset(1);
        last_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R8 reset valid", DW'(rd_valid), '0);
        check("R8 reset pwr_down", DW'(pwr_down), '0);
        do_read(0, "R8 ctrl0 default");
        do_read(31, "R2 page reset");
        do_read(20, "R8 main default");
        // R7 masks on the main page
        do_write(5, 16'hFFFF);  do_read(5, "R7 main low");
        do_write(20, 16'hFFFF); do_read(20, "R7 main high");
        do_write(0, 16'h7FFF);  do_read(0, "R7 ctrl0 mask");
        // R3 and R12: read right after the page change
        do_write(31, 16'h0001); do_read(20, "R12 ext1 immediate");
        do_write(20, 16'hFFFF); do_read(20, "R3 ext1 mask");
        do_read(5, "R3 low stays main");
        // R4
        do_write(31, 16'h0002); do_write(20, 16'hFFFF); do_read(20, "R4 ext2 mask");
        // R6: unknown code falls back to main
        do_write(31, 16'h0003); do_read(20, "R6 unknown page");
        // R5 and R2 reserved bits of the selector
        do_write(31, 16'h0110); do_read(31, "R2 page reserved");
        do_write(0, 16'hFFFF);  do_read(0, "R5 gp addr0 no reset");
        do_write(5, 16'h1234);  do_read(5, "R5 gp reg");
        // R9 soft reset and R10 sticky bits
        do_write(31, 16'h0000); do_write(0, 16'h0800); do_read(0, "R11 pd set");
        do_write(0, 16'h8000);  do_read(31, "R9 page cleared");
        do_read(0, "R9 ctrl0 default");
        do_read(20, "R10 main sticky");
        do_write(31, 16'h0001); do_read(20, "R10 ext1 sticky");
        do_write(31, 16'h0002); do_read(20, "R10 ext2 sticky");
        do_write(31, 16'h0010); do_read(0, "R10 gp sticky");
        // Random mix
        for (int n = 0; n < 2000; n++) begin
            sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                case ($urandom_range(0, 5))
                    0: d = 16'h0000; 1: d = 16'h0001; 2: d = 16'h0002;
                    3: d = 16'h0010; default: d = DW'($urandom);
                endcase
                do_write(31, d);
            end else begin
                a = int'($urandom_range(0, 31));
                d = DW'($urandom);
                if (a == 0 && $urandom_range(0, 7) != 0) d[15] = 1'b0;
                if (sel < 5) do_write(a, d);
                else do_read(a, "R7 random read");
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule